// File: doc/BRIEF.md
# Four-Mode Serial Port with Multiprocessor Filtering

This block is a full-duplex serial port reached through a small register bus. It has two registers. The control register selects one of four modes, holds the receive-enable, multiprocessor-filter and ninth-bit controls, and carries the two interrupt flags. The data register is write-to-send and read-to-receive; the transmit and receive halves are separate storage behind the same address.

Mode 0 is a synchronous shifter running at half the core clock: data moves on the RxD pin, LSB first, and TxD carries the shift clock. Modes 1 to 3 are asynchronous frames sent LSB first. Each frame has one start bit, eight data bits, an optional ninth bit and one stop bit. The bit time is 16 ticks of an oversampling clock. Modes 1 and 3 take this clock from an external tick input. Mode 2 derives it from the core clock: 32 core cycles per bit, or 16 when the rate-double input is high. In the 9-bit modes the receiver can drop frames whose ninth bit is 0, which lets one node listen only for address frames. The receive side holds one buffered byte. A byte that completes while the previous one is still unread replaces it.

Top module: `sio_top`

## Requirements
- R1: After reset the control register reads 00h, TxD is high, RxD is not driven and both interrupt flags are low.
- R2: The control register sits at address 98h. Its fields are: bits [7:6] mode (00 shift, 01 8-bit async, 10 9-bit fixed rate, 11 9-bit variable rate), bit 5 multiprocessor filter, bit 4 receive enable, bit 3 transmit ninth bit, bit 2 received ninth bit, bit 1 transmit flag, bit 0 receive flag. Every bit reads back what was last written unless hardware has set it since. An address that is neither 98h nor 99h reads 00h.
- R3: A write to address 99h starts a transmission. A read of 99h returns the receive buffer, and that value is unchanged by the write.
- R4: An async frame is a 0 start bit, then the data LSB first, then in modes 2 and 3 the transmit ninth bit, then a 1 stop bit. Each bit lasts 16 oversampling ticks. Modes 1 and 3 count the external tick input. Mode 2 ticks every core cycle when rate-double is high and every second core cycle when it is low.
- R5: The transmit flag rises at the start of the stop bit in modes 1 to 3 and after the eighth bit in mode 0. Once set it stays set until software writes the control register.
- R6: In modes 1 to 3 the receive flag rises halfway through the stop bit. Once set it stays set until software writes the control register.
- R7: In modes 2 and 3 the received ninth bit is stored in control bit 2. In mode 1 that bit stores the received stop bit.
- R8: With the filter bit set, a frame is discarded and the flag stays low when the mode 1 stop bit is 0, or when the ninth bit is 0 in modes 2 and 3. With the filter bit clear, every completed frame is kept and sets the flag.
- R9: A byte that completes while the receive flag is still set overwrites the buffered byte.
- R10: Nothing is received while receive enable is clear.
- R11: Each received bit is the 2-of-3 majority of samples taken at ticks 7, 8 and 9 of the bit. A start bit that votes high is abandoned, so a low glitch shorter than half a bit is ignored.
- R12: In mode 0, a transmit drives RxD with the data LSB first. Each bit lasts two core cycles: TxD is low in the first and high in the second. This repeats 8 times.
- R13: In mode 0, reception runs whenever receive enable is 1 and the receive flag is 0. TxD is driven as the same shift clock, and RxD is sampled at the end of each low phase. The flag is set after the eighth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| baud_tick | input | 1 | Oversampling tick for modes 1 and 3 |
| rate_double | input | 1 | Mode 2 rate select, 1 = core/16 |
| rxd_in | input | 1 | RxD pin input |
| rxd_out | output | 1 | RxD pin output value in mode 0 |
| rxd_oe | output | 1 | RxD output enable in mode 0 transmit |
| txd_out | output | 1 | TxD pin: serial data or shift clock |
| tx_irq | output | 1 | Transmit flag |
| rx_irq | output | 1 | Receive flag |

## Verification
The hardest case to reach is the multiprocessor filter rejecting a frame. The frame has to arrive complete and well timed but carry a 0 in the ninth bit, or a bad stop bit in mode 1, and the bench must then show that neither the buffer nor the flag moved. A table of receive vectors walks the modes and filter settings. The bench drives each frame bit by bit on RxD, and rejected entries expect the buffer value left by the entry before. Overrun, a short glitch on the start bit, and mode 0 reception are driven as directed sequences. In mode 0 the bench follows the shift clock on TxD and presents each data bit during the low phase.

// File: rtl/sio_pkg.sv
package sio_pkg;
    typedef enum logic [1:0] {
        MODE_SHIFT = 2'b00,
        MODE_ASYNC8 = 2'b01,
        MODE_FIX9 = 2'b10,
        MODE_VAR9 = 2'b11
    } sio_mode_e;

    function automatic logic [3:0] stop_index(sio_mode_e m);
        return (m == MODE_ASYNC8) ? 4'd9 : 4'd10;
    endfunction
endpackage

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  sio_mode_e mode,
    input  logic      tick,
    input  logic      load,
    input  logic [7:0] din,
    input  logic      tb8,
    output logic      txd,
    output logic      sdata,
    output logic      sdata_oe,
    output logic      ti_set
);
    localparam int SW = $clog2(OVS);

    typedef struct packed {
        logic          busy;
        logic          phase;
        logic [3:0]    idx;
        logic [SW-1:0] sub;
        logic [10:0]   frame;
    } tx_s;

    tx_s q, d;
    logic [3:0] nxt;

    always_comb begin
        d = q;
        ti_set = 1'b0;
        nxt = q.idx + 4'd1;
        if (load) begin
            d.busy = 1'b1;
            d.phase = 1'b0;
            d.idx = '0;
            d.sub = '0;
            if (mode == MODE_SHIFT) d.frame = {3'b111, din};
            else d.frame = {1'b1, (mode == MODE_ASYNC8) ? 1'b1 : tb8, din, 1'b0};
        end else if (q.busy) begin
            if (mode == MODE_SHIFT) begin
                d.phase = ~q.phase;
                if (q.phase) begin
                    if (q.idx == 4'd7) begin
                        d.busy = 1'b0;
                        ti_set = 1'b1;
                    end else begin
                        d.idx = nxt;
                    end
                end
            end else if (tick) begin
                d.sub = q.sub + 1'b1;
                if (q.sub == SW'(OVS - 1)) begin
                    if (q.idx == stop_index(mode)) begin
                        d.busy = 1'b0;
                    end else begin
                        d.idx = nxt;
                        if (nxt == stop_index(mode)) ti_set = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else q <= d;
    end

    assign txd = !q.busy ? 1'b1 : ((mode == MODE_SHIFT) ? q.phase : q.frame[q.idx]);
    assign sdata = q.frame[q.idx[2:0]];
    assign sdata_oe = q.busy && (mode == MODE_SHIFT);
endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  sio_mode_e mode,
    input  logic      tick,
    input  logic      ren,
    input  logic      sm2,
    input  logic      ri_now,
    input  logic      rxd,
    input  logic      rxd_raw,
    output logic      sclk,
    output logic      done,
    output logic      accept,
    output logic      bit9,
    output logic [7:0] rdata
);
    localparam int SW = $clog2(OVS);
    localparam int MID = OVS / 2;

    typedef struct packed {
        logic          active;
        logic          sh;
        logic          armed;
        logic          phase;
        logic [3:0]    idx;
        logic [SW-1:0] sub;
        logic [1:0]    smp;
        logic [8:0]    data;
    } rx_s;

    rx_s q, d;
    logic vote;

    assign vote = (q.smp[1] & q.smp[0]) | (q.smp[1] & rxd) | (q.smp[0] & rxd);
    assign bit9 = (mode == MODE_ASYNC8) ? vote : q.data[8];
    assign rdata = (mode == MODE_FIX9 || mode == MODE_VAR9) ? q.data[7:0] : q.data[8:1];

    always_comb begin
        d = q;
        done = 1'b0;
        accept = 1'b0;
        if (!q.active) begin
            if (rxd) d.armed = 1'b1;
            if (mode == MODE_SHIFT) begin
                if (ren && !ri_now) begin
                    d.active = 1'b1;
                    d.sh = 1'b1;
                    d.phase = 1'b0;
                    d.idx = '0;
                end
            end else if (tick && ren && q.armed && !rxd) begin
                d.active = 1'b1;
                d.sh = 1'b0;
                d.armed = 1'b0;
                d.idx = '0;
                d.sub = SW'(1);
            end
        end else if (!ren) begin
            d.active = 1'b0;
        end else if (q.sh) begin
            d.phase = ~q.phase;
            if (!q.phase) begin
                d.data = {rxd_raw, q.data[8:1]};
            end else if (q.idx == 4'd7) begin
                d.active = 1'b0;
                done = 1'b1;
                accept = 1'b1;
            end else begin
                d.idx = q.idx + 4'd1;
            end
        end else if (tick) begin
            d.sub = q.sub + 1'b1;
            if (q.sub == SW'(MID - 1) || q.sub == SW'(MID)) d.smp = {q.smp[0], rxd};
            if (q.sub == SW'(MID + 1)) begin
                if (q.idx == 4'd0) begin
                    if (vote) d.active = 1'b0;
                end else if (q.idx == stop_index(mode)) begin
                    d.active = 1'b0;
                    done = 1'b1;
                    accept = !sm2 || bit9;
                end else begin
                    d.data = {vote, q.data[8:1]};
                end
            end
            if (q.sub == SW'(OVS - 1)) d.idx = q.idx + 4'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else q <= d;
    end

    assign sclk = !(q.active && q.sh && !q.phase);
endmodule

// File: rtl/sio_top.sv
module sio_top
    import sio_pkg::*;
#(
    parameter int         OVS       = 16,
    parameter logic [7:0] CTRL_ADDR = 8'h98,
    parameter logic [7:0] DATA_ADDR = 8'h99
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_addr,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       baud_tick,
    input  logic       rate_double,
    input  logic       rxd_in,
    output logic       rxd_out,
    output logic       rxd_oe,
    output logic       txd_out,
    output logic       tx_irq,
    output logic       rx_irq
);
    typedef struct packed {
        logic [7:0] ctrl;
        logic [7:0] rbuf;
        logic       div;
        logic [1:0] sync;
    } top_s;

    top_s q, d;
    logic [7:0] ctrl_q;
    sio_mode_e mode;
    logic tick, tx_load, ti_set, tx_txd;
    logic rx_sclk, rx_done, rx_acc, rx_b9;
    logic [7:0] rx_data;

    assign ctrl_q = q.ctrl;
    assign mode = sio_mode_e'(q.ctrl[7:6]);
    assign tick = (mode == MODE_FIX9) ? (rate_double | q.div) : baud_tick;
    assign tx_load = bus_we && (bus_addr == DATA_ADDR);

    sio_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .mode(mode), .tick(tick), .load(tx_load),
        .din(bus_wdata), .tb8(q.ctrl[3]), .txd(tx_txd), .sdata(rxd_out),
        .sdata_oe(rxd_oe), .ti_set(ti_set)
    );

    sio_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .mode(mode), .tick(tick), .ren(q.ctrl[4]),
        .sm2(q.ctrl[5]), .ri_now(q.ctrl[0]), .rxd(q.sync[1]), .rxd_raw(rxd_in),
        .sclk(rx_sclk), .done(rx_done), .accept(rx_acc), .bit9(rx_b9),
        .rdata(rx_data)
    );

    always_comb begin
        d = q;
        d.div = ~q.div;
        d.sync = {q.sync[0], rxd_in};
        if (bus_we && bus_addr == CTRL_ADDR) d.ctrl = bus_wdata;
        if (ti_set) d.ctrl[1] = 1'b1;
        if (rx_done && rx_acc) begin
            d.rbuf = rx_data;
            d.ctrl[0] = 1'b1;
            if (mode != MODE_SHIFT) d.ctrl[2] = rx_b9;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ctrl: 8'h00, rbuf: 8'h00, div: 1'b0, sync: 2'b11};
        else q <= d;
    end

    always_comb begin
        if (bus_addr == CTRL_ADDR) bus_rdata = q.ctrl;
        else if (bus_addr == DATA_ADDR) bus_rdata = q.rbuf;
        else bus_rdata = 8'h00;
    end

    assign txd_out = tx_txd & rx_sclk;
    assign tx_irq = q.ctrl[1];
    assign rx_irq = q.ctrl[0];
endmodule

// File: rtl/sio_checker.sv
module sio_checker #(
    parameter logic [7:0] CTRL_ADDR = 8'h98
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_we,
    input logic [7:0] bus_addr,
    input logic       tx_irq,
    input logic       rx_irq,
    input logic [7:0] ctrl
);
    logic cw;
    assign cw = bus_we && (bus_addr == CTRL_ADDR);

    p_ti_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq && !cw |=> tx_irq);

    p_ri_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq && !cw |=> rx_irq);

    p_ren_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) && !$past(cw) |-> ctrl[4]);

    p_mp_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) && !$past(cw) && ctrl[5] && ctrl[7:6] != 2'b00 |-> ctrl[2]);
endmodule

bind sio_top sio_checker #(.CTRL_ADDR(CTRL_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .ctrl(ctrl_q)
);

// File: tb/tb_sio_top.sv
module tb_sio_top;
    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00, bus_rdata;
    logic bus_we = 1'b0, baud_tick = 1'b1, rate_double = 1'b1, rxd_in = 1'b1;
    logic rxd_out, rxd_oe, txd_out, tx_irq, rx_irq;
    int tests = 0, fails = 0;

    always #4 clk = ~clk;

    sio_top dut (.*);

    // {mode[1:0], filter, data[7:0], ninth/stop, exp_flag, exp_buf[7:0], exp_b9}
    localparam int NV = 7;
    localparam logic [21:0] VEC [NV] = '{
        {2'b01, 1'b0, 8'hA5, 1'b1, 1'b1, 8'hA5, 1'b1},
        {2'b01, 1'b1, 8'h11, 1'b0, 1'b0, 8'hA5, 1'b0},
        {2'b01, 1'b0, 8'h3C, 1'b0, 1'b1, 8'h3C, 1'b0},
        {2'b11, 1'b1, 8'h22, 1'b0, 1'b0, 8'h3C, 1'b0},
        {2'b11, 1'b1, 8'h81, 1'b1, 1'b1, 8'h81, 1'b1},
        {2'b10, 1'b0, 8'h7E, 1'b0, 1'b1, 8'h7E, 1'b0},
        {2'b11, 1'b0, 8'hC3, 1'b1, 1'b1, 8'hC3, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic send(input logic [10:0] bits, input int n, input int per);
        for (int i = 0; i < n; i++) begin
            rxd_in = bits[i];
            repeat (per) @(negedge clk);
        end
        rxd_in = 1'b1;
        repeat (per) @(negedge clk);
    endtask

    task automatic capture(input int n, input int per, output logic [10:0] bits,
                           output logic ti_pre, output logic ti_stop);
        int guard = 0;
        bits = '0; ti_pre = 1'bx; ti_stop = 1'bx;
        while (txd_out !== 1'b0 && guard < 200) begin
            @(negedge clk); guard++;
        end
        repeat (per / 2) @(negedge clk);
        bits[0] = txd_out;
        for (int i = 1; i < n; i++) begin
            repeat (per) @(negedge clk);
            bits[i] = txd_out;
            if (i == n - 2) ti_pre = tx_irq;
            if (i == n - 1) ti_stop = tx_irq;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [10:0] bits;
        logic tp, ts;
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h98, v); check("R1 ctrl", v, 8'h00);
        check("R1 txd", txd_out, 1'b1);
        check("R1 oe", rxd_oe, 1'b0);
        check("R1 flags", {tx_irq, rx_irq}, 2'b00);
        // R2 register map
        rd(8'h50, v); check("R2 unmapped", v, 8'h00);
        wr(8'h98, 8'h6C); rd(8'h98, v); check("R2 readback", v, 8'h6C);
        wr(8'h98, 8'h00);

        // R4 R5 mode 3 frame with ninth bit 1
        wr(8'h98, 8'hC8); wr(8'h99, 8'h96);
        capture(11, 16, bits, tp, ts);
        check("R4 mode3 frame", bits, {1'b1, 1'b1, 8'h96, 1'b0});
        check("R5 ti before stop", tp, 1'b0);
        check("R5 ti at stop", ts, 1'b1);
        repeat (20) @(negedge clk);
        check("R5 ti sticky", tx_irq, 1'b1);
        // R3 data read unaffected by write
        rd(8'h99, v); check("R3 rx buffer separate", v, 8'h00);
        // R4 mode 1
        wr(8'h98, 8'h40); wr(8'h99, 8'h5B);
        capture(10, 16, bits, tp, ts);
        check("R4 mode1 frame", bits[9:0], {1'b1, 8'h5B, 1'b0});
        check("R5 mode1 ti at stop", {tp, ts}, 2'b01);
        repeat (20) @(negedge clk);
        // R4 mode 2 at core/32, ninth bit 0
        rate_double = 1'b0;
        wr(8'h98, 8'h80); wr(8'h99, 8'hE1);
        capture(11, 32, bits, tp, ts);
        check("R4 mode2 slow frame", bits, {1'b1, 1'b0, 8'hE1, 1'b0});
        repeat (40) @(negedge clk);
        rate_double = 1'b1;

        // R6 R7 R8 receive vectors
        for (int i = 0; i < NV; i++) begin
            logic [21:0] e;
            logic [10:0] fr;
            e = VEC[i];
            wr(8'h98, {e[21:20], e[19], 1'b1, 4'b0000});
            if (e[21:20] == 2'b01) begin
                fr = {1'b1, e[10], e[18:11], 1'b0};
                send(fr, 10, 16);
            end else begin
                fr = {1'b1, e[10], e[18:11], 1'b0};
                send(fr, 11, 16);
            end
            repeat (8) @(negedge clk);
            rd(8'h98, v);
            check($sformatf("R6 R8 flag vec%0d", i), v[0], e[9]);
            check($sformatf("R7 ninth vec%0d", i), v[2], e[0]);
            rd(8'h99, v);
            check($sformatf("R8 buffer vec%0d", i), v, e[8:1]);
        end

        // R9 overrun
        wr(8'h98, 8'h50);
        send({2'b11, 8'h12, 1'b0}, 10, 16);
        send({2'b11, 8'h34, 1'b0}, 10, 16);
        repeat (8) @(negedge clk);
        rd(8'h99, v); check("R9 overwrite", v, 8'h34);
        check("R9 flag", rx_irq, 1'b1);
        // R10 receive disabled
        wr(8'h98, 8'h40);
        send({2'b11, 8'h55, 1'b0}, 10, 16);
        repeat (8) @(negedge clk);
        check("R10 no flag", rx_irq, 1'b0);
        rd(8'h99, v); check("R10 buffer kept", v, 8'h34);
        // R11 glitch rejection then valid frame
        wr(8'h98, 8'h50);
        rxd_in = 1'b0; repeat (5) @(negedge clk); rxd_in = 1'b1;
        repeat (40) @(negedge clk);
        check("R11 glitch ignored", rx_irq, 1'b0);
        send({2'b11, 8'h6A, 1'b0}, 10, 16);
        repeat (8) @(negedge clk);
        rd(8'h99, v); check("R11 frame after glitch", v, 8'h6A);

        // R12 mode 0 transmit
        wr(8'h98, 8'h00); wr(8'h99, 8'hB4);
        k = 0; v = 8'h00; tp = 1'b1;
        bus_addr = 8'h00;
        for (int c = 0; c < 24; c++) begin
            if (txd_out === 1'b0) begin
                if (k < 8) v[k] = rxd_out;
                if (rxd_oe !== 1'b1) tp = 1'b0;
                k++;
            end
            @(negedge clk);
        end
        check("R12 clock pulses", k, 8);
        check("R12 data", v, 8'hB4);
        check("R12 oe during shift", tp, 1'b1);
        check("R12 oe released", rxd_oe, 1'b0);
        check("R5 mode0 ti", tx_irq, 1'b1);

        // R13 mode 0 receive
        wr(8'h98, 8'h10);
        k = 0;
        for (int c = 0; c < 30; c++) begin
            if (txd_out === 1'b0) begin
                if (k < 8) rxd_in = 8'h5D >> k;
                k++;
            end
            @(negedge clk);
        end
        rxd_in = 1'b1;
        check("R13 clock pulses", k, 8);
        check("R13 flag", rx_irq, 1'b1);
        rd(8'h99, v); check("R13 data", v, 8'h5D);
        repeat (30) @(negedge clk);
        check("R6 ri sticky", rx_irq, 1'b1);
        wr(8'h98, 8'h00);
        check("R6 ri cleared by write", rx_irq, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule